// File: doc/BRIEF.md
# Receive Frame Admission Controller

This block sits between the line side of a network receiver and its packet FIFO. Each arriving frame is presented as a single-cycle beat that carries its byte length. The block counts every arrival, in bytes and in frames. It then decides in one pass whether the frame is discarded quietly, refused for lack of space, or pushed into the FIFO. The FIFO storage and the address-match logic sit outside this block. The block receives their results as plain inputs: the FIFO fill level, a "frame fits" indication, and a drop verdict from the filter.

The wire side is a valid/ready stream. `in_ready` is tied high, because the decision is made in the arrival cycle and the block never stalls the line. Back-pressure is not applied as a stall. It is reported afterwards as a failure response. The FIFO side is also valid/ready. `push_valid` is raised combinationally in the arrival cycle when a push is attempted. `push_ready` is the FIFO's answer in that same cycle, and a push happens only when both are high. A quiet discard, caused by receive disabled or by a filter drop, is answered with a success response so that the sender treats the frame as consumed. A frame that does not fit is answered with a failure response. All responses, interrupts and side pulses are registered and appear for exactly one cycle, one clock after the arrival.

Top module: `rx_admit_ctrl`

## Requirements
- R1: Every accepted arrival beat (`in_valid`) adds `in_len` to `byte_count` and 1 to `pkt_count`, both visible one cycle later, whatever the fate of the frame. Both counters wrap modulo 2^32.
- R2: When `rx_enable` is 0, `push_valid` stays 0 and one cycle later `resp_ok` pulses. No interrupt or side pulse is raised.
- R3: When `filt_enable` and `filt_drop` are both 1, `push_valid` stays 0 and one cycle later `resp_ok` pulses with no interrupt. When `filt_enable` is 0, `filt_drop` has no effect.
- R4: When a push is attempted and `fifo_level >= high_mark`, sampled in the arrival cycle before the push, `irq_rx_high` pulses one cycle later. This happens whether or not the push succeeds.
- R5: When a push is attempted and `push_ready` is 0, one cycle later `resp_fail` pulses and none of `resp_ok`, `irq_rx_pkt`, `rx_kick` or `rdptr_backup` pulse.
- R6: When a push is attempted and `push_ready` is 1, one cycle later `resp_ok`, `irq_rx_pkt` and `rx_kick` pulse together.
- R7: On a successful push with `rdptr_at_end` = 1, `rdptr_backup` pulses one cycle later. With `rdptr_at_end` = 0 it stays low.
- R8: `in_ready` is always 1. A push is attempted in the arrival cycle with `push_len` equal to `in_len`. Each arrival yields exactly one of `resp_ok` or `resp_fail`, and no pulse appears without an arrival.
- R9: A synchronous reset `rst` clears both counters and all pulse outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Frame arrival beat |
| in_ready | output | 1 | Always 1; wire side never stalls |
| in_len | input | LEN_W | Frame length in bytes |
| rx_enable | input | 1 | Receive enable |
| filt_enable | input | 1 | Filter enable configuration bit |
| filt_drop | input | 1 | Filter verdict: 1 = drop |
| fifo_level | input | LVL_W | FIFO occupancy before the push |
| high_mark | input | LVL_W | Programmable high-water mark |
| push_valid | output | 1 | Push attempt to FIFO |
| push_ready | input | 1 | FIFO can hold the frame |
| push_len | output | LEN_W | Length of the pushed frame |
| rdptr_at_end | input | 1 | Receive read pointer sits at FIFO end |
| resp_ok | output | 1 | Pulse: frame consumed (pushed or quietly discarded) |
| resp_fail | output | 1 | Pulse: frame refused, no room |
| irq_rx_high | output | 1 | Pulse: high-water interrupt |
| irq_rx_pkt | output | 1 | Pulse: packet-received interrupt |
| rx_kick | output | 1 | Pulse: start the receive state machine |
| rdptr_backup | output | 1 | Pulse: move read pointer back to the new last entry |
| byte_count | output | CNT_W | Received byte counter |
| pkt_count | output | CNT_W | Received frame counter |

## Verification
The high-water interrupt and the push outcome come from the same arrival cycle, so they can fall together. A frame can raise `irq_rx_high` together with `resp_fail`, or together with the full success set. The bench provokes both pairings with directed frames that set `fifo_level` equal to `high_mark`, and also through random levels and marks with `push_ready` drawn at random. A per-frame bench function judges each output pulse independently and predicts the full set of pulses from the requirements.

// File: rtl/rx_admit_pkg.sv
package rx_admit_pkg;
  typedef enum logic [1:0] {
    VERDICT_NONE    = 2'd0,
    VERDICT_DISCARD = 2'd1,
    VERDICT_PUSH    = 2'd2
  } verdict_e;
endpackage

// File: rtl/rx_admit_counters.sv
module rx_admit_counters #(
  parameter int LEN_W = 16,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arrive,
  input  logic [LEN_W-1:0] len,
  output logic [CNT_W-1:0] bytes_q,
  output logic [CNT_W-1:0] frames_q
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      bytes_q  <= '0;
      frames_q <= '0;
      armed    <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (arrive) begin
        bytes_q  <= bytes_q + CNT_W'(len);
        frames_q <= frames_q + 1'b1;
      end
    end
  end

  // R1: frame counter moves by exactly the arrival bit of the prior cycle
  assert_frame_step_R1: assert property (@(posedge clk) disable iff (rst || !armed)
    frames_q == $past(frames_q) + CNT_W'($past(arrive)));
  // R1: byte counter holds when nothing arrived
  assert_bytes_hold_R1: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(arrive) |-> $stable(bytes_q));
endmodule

// File: rtl/rx_admit_gate.sv
module rx_admit_gate
  import rx_admit_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic             arrive,
  input  logic             rx_enable,
  input  logic             filt_enable,
  input  logic             filt_drop,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] high_mark,
  output verdict_e         verdict,
  output logic             over_mark
);
  always_comb begin
    verdict = VERDICT_NONE;
    if (arrive) begin
      if (!rx_enable)                    verdict = VERDICT_DISCARD;
      else if (filt_enable && filt_drop) verdict = VERDICT_DISCARD;
      else                               verdict = VERDICT_PUSH;
    end
  end

  assign over_mark = (verdict == VERDICT_PUSH) && (fifo_level >= high_mark);

  // R2: a disabled receiver never attempts a push
  always_comb assert_no_push_disabled_R2: assert (!(verdict == VERDICT_PUSH && !rx_enable));
  // R3: an enabled filter drop never attempts a push
  always_comb assert_no_push_filtered_R3: assert (!(verdict == VERDICT_PUSH && filt_enable && filt_drop));
endmodule

// File: rtl/rx_admit_resp.sv
module rx_admit_resp
  import rx_admit_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  verdict_e verdict,
  input  logic     over_mark,
  input  logic     push_ready,
  input  logic     rdptr_at_end,
  output logic     resp_ok,
  output logic     resp_fail,
  output logic     irq_rx_high,
  output logic     irq_rx_pkt,
  output logic     rx_kick,
  output logic     rdptr_backup
);
  logic pushed, refused, armed;

  assign pushed  = (verdict == VERDICT_PUSH) && push_ready;
  assign refused = (verdict == VERDICT_PUSH) && !push_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_ok      <= 1'b0;
      resp_fail    <= 1'b0;
      irq_rx_high  <= 1'b0;
      irq_rx_pkt   <= 1'b0;
      rx_kick      <= 1'b0;
      rdptr_backup <= 1'b0;
      armed        <= 1'b0;
    end else begin
      armed        <= 1'b1;
      resp_ok      <= (verdict == VERDICT_DISCARD) || pushed;
      resp_fail    <= refused;
      irq_rx_high  <= over_mark;
      irq_rx_pkt   <= pushed;
      rx_kick      <= pushed;
      rdptr_backup <= pushed && rdptr_at_end;
    end
  end

  // R8: never both responses at once
  assert_one_resp_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({resp_ok, resp_fail}));
  // R5: a refusal follows a push attempt the FIFO declined
  assert_fail_cause_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    resp_fail |-> ($past(verdict) == VERDICT_PUSH && !$past(push_ready)));
  // R6: packet interrupt only alongside a success response and kick
  assert_pkt_with_ok_R6: assert property (@(posedge clk) disable iff (rst)
    irq_rx_pkt |-> (resp_ok && rx_kick));
  // R7: pointer backup only on a packet interrupt
  assert_backup_on_push_R7: assert property (@(posedge clk) disable iff (rst)
    rdptr_backup |-> irq_rx_pkt);
  // R4: high-water interrupt only after a push attempt
  assert_high_needs_push_R4: assert property (@(posedge clk) disable iff (rst || !armed)
    irq_rx_high |-> ($past(verdict) == VERDICT_PUSH));
endmodule

// File: rtl/rx_admit_ctrl.sv
module rx_admit_ctrl
  import rx_admit_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int LVL_W = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [LEN_W-1:0] in_len,
  input  logic             rx_enable,
  input  logic             filt_enable,
  input  logic             filt_drop,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] high_mark,
  output logic             push_valid,
  input  logic             push_ready,
  output logic [LEN_W-1:0] push_len,
  input  logic             rdptr_at_end,
  output logic             resp_ok,
  output logic             resp_fail,
  output logic             irq_rx_high,
  output logic             irq_rx_pkt,
  output logic             rx_kick,
  output logic             rdptr_backup,
  output logic [CNT_W-1:0] byte_count,
  output logic [CNT_W-1:0] pkt_count
);
  verdict_e verdict;
  logic     over_mark;
  logic     arrive;

  assign in_ready   = 1'b1;
  assign arrive     = in_valid && in_ready;
  assign push_valid = (verdict == VERDICT_PUSH);
  assign push_len   = in_len;

  rx_admit_counters #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_counters (
    .clk(clk), .rst(rst), .arrive(arrive), .len(in_len),
    .bytes_q(byte_count), .frames_q(pkt_count)
  );

  rx_admit_gate #(.LVL_W(LVL_W)) u_gate (
    .arrive(arrive), .rx_enable(rx_enable), .filt_enable(filt_enable),
    .filt_drop(filt_drop), .fifo_level(fifo_level), .high_mark(high_mark),
    .verdict(verdict), .over_mark(over_mark)
  );

  rx_admit_resp u_resp (
    .clk(clk), .rst(rst), .verdict(verdict), .over_mark(over_mark),
    .push_ready(push_ready), .rdptr_at_end(rdptr_at_end),
    .resp_ok(resp_ok), .resp_fail(resp_fail), .irq_rx_high(irq_rx_high),
    .irq_rx_pkt(irq_rx_pkt), .rx_kick(rx_kick), .rdptr_backup(rdptr_backup)
  );

  // R8: the wire side is never stalled
  always_comb assert_ready_high_R8: assert (in_ready);
  // R8: no push attempt without an arrival
  always_comb assert_push_needs_arrival_R8: assert (!push_valid || in_valid);
endmodule

// File: tb/rx_admit_ctrl_bench.sv
module rx_admit_ctrl_bench;
  localparam int LEN_W = 16;
  localparam int LVL_W = 8;
  localparam int CNT_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [LEN_W-1:0] in_len = '0;
  logic rx_enable = 1'b0, filt_enable = 1'b0, filt_drop = 1'b0;
  logic [LVL_W-1:0] fifo_level = '0, high_mark = '0;
  logic push_valid, push_ready = 1'b0;
  logic [LEN_W-1:0] push_len;
  logic rdptr_at_end = 1'b0;
  logic resp_ok, resp_fail, irq_rx_high, irq_rx_pkt, rx_kick, rdptr_backup;
  logic [CNT_W-1:0] byte_count, pkt_count;

  int checks = 0;
  int failures = 0;
  logic [CNT_W-1:0] exp_bytes = '0;
  logic [CNT_W-1:0] exp_pkts = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rx_admit_ctrl #(.LEN_W(LEN_W), .LVL_W(LVL_W), .CNT_W(CNT_W)) u_rx_admit_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_len(in_len),
    .rx_enable(rx_enable), .filt_enable(filt_enable), .filt_drop(filt_drop),
    .fifo_level(fifo_level), .high_mark(high_mark), .push_valid(push_valid),
    .push_ready(push_ready), .push_len(push_len), .rdptr_at_end(rdptr_at_end),
    .resp_ok(resp_ok), .resp_fail(resp_fail), .irq_rx_high(irq_rx_high),
    .irq_rx_pkt(irq_rx_pkt), .rx_kick(rx_kick), .rdptr_backup(rdptr_backup),
    .byte_count(byte_count), .pkt_count(pkt_count)
  );

  // Expected pulses {ok, fail, high, pkt, kick, backup}
  function automatic logic [5:0] predict(input logic en, input logic fe, input logic fd,
      input logic [LVL_W-1:0] lvl, input logic [LVL_W-1:0] mark,
      input logic rdy, input logic atend);
    logic pv;
    pv = en && !(fe && fd);
    return {(!pv) || rdy, pv && !rdy, pv && (lvl >= mark), pv && rdy, pv && rdy,
            pv && rdy && atend};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [LEN_W-1:0] len, input logic en, input logic fe,
      input logic fd, input logic [LVL_W-1:0] lvl, input logic [LVL_W-1:0] mark,
      input logic rdy, input logic atend, input string tag);
    logic [5:0] e;
    e = predict(en, fe, fd, lvl, mark, rdy, atend);
    in_valid = 1'b1; in_len = len; rx_enable = en; filt_enable = fe; filt_drop = fd;
    fifo_level = lvl; high_mark = mark; push_ready = rdy; rdptr_at_end = atend;
    #1;
    check({tag, " R8 in_ready"}, 64'(in_ready), 64'd1);
    check({tag, " R2/R3 push_valid"}, 64'(push_valid), 64'(en && !(fe && fd)));
    if (push_valid) check({tag, " R8 push_len"}, 64'(push_len), 64'(len));
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    exp_bytes = exp_bytes + CNT_W'(len);
    exp_pkts  = exp_pkts + 1;
    check({tag, " R1 byte_count"}, 64'(byte_count), 64'(exp_bytes));
    check({tag, " R1 pkt_count"}, 64'(pkt_count), 64'(exp_pkts));
    check({tag, " R5/R6/R8 resp_ok"}, 64'(resp_ok), 64'(e[5]));
    check({tag, " R5 resp_fail"}, 64'(resp_fail), 64'(e[4]));
    check({tag, " R4 irq_rx_high"}, 64'(irq_rx_high), 64'(e[3]));
    check({tag, " R6 irq_rx_pkt"}, 64'(irq_rx_pkt), 64'(e[2]));
    check({tag, " R6 rx_kick"}, 64'(rx_kick), 64'(e[1]));
    check({tag, " R7 rdptr_backup"}, 64'(rdptr_backup), 64'(e[0]));
  endtask

  task automatic idle_check(input string tag);
    @(posedge clk);
    @(negedge clk);
    check({tag, " R8 no pulse when idle"},
          64'({resp_ok, resp_fail, irq_rx_high, irq_rx_pkt, rx_kick, rdptr_backup}), 64'd0);
    check({tag, " R1 counters hold"}, 64'(pkt_count), 64'(exp_pkts));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 byte_count reset", 64'(byte_count), 64'd0);
    check("R9 pkt_count reset", 64'(pkt_count), 64'd0);
    check("R9 pulses reset",
          64'({resp_ok, resp_fail, irq_rx_high, irq_rx_pkt, rx_kick, rdptr_backup}), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // Directed corners
    frame(16'd60,   1'b0, 1'b0, 1'b0, 8'd3,  8'd5,  1'b1, 1'b1, "disabled R2");
    frame(16'd64,   1'b0, 1'b1, 1'b1, 8'd9,  8'd5,  1'b0, 1'b0, "disabled+filter R2");
    frame(16'd70,   1'b1, 1'b1, 1'b1, 8'd9,  8'd5,  1'b0, 1'b1, "filtered R3");
    frame(16'd72,   1'b1, 1'b0, 1'b1, 8'd1,  8'd5,  1'b1, 1'b0, "filter off R3");
    frame(16'd1500, 1'b1, 1'b0, 1'b0, 8'd5,  8'd5,  1'b0, 1'b0, "high+fail R4 R5");
    frame(16'd1514, 1'b1, 1'b0, 1'b0, 8'd5,  8'd5,  1'b1, 1'b1, "high+push R4 R6 R7");
    frame(16'd100,  1'b1, 1'b0, 1'b0, 8'd4,  8'd5,  1'b1, 1'b0, "below mark R4 R6");
    frame(16'd0,    1'b1, 1'b0, 1'b0, 8'd0,  8'd0,  1'b1, 1'b1, "zero len mark0 R1 R4");
    frame(16'hFFFF, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF, 1'b0, 1'b1, "max fail R5 R7");
    idle_check("after directed");

    // Back-to-back random frames
    for (int i = 0; i < 400; i++) begin
      logic [LVL_W-1:0] lv, mk;
      lv = LVL_W'($urandom_range(0, 15));
      mk = LVL_W'($urandom_range(0, 15));
      frame(LEN_W'($urandom), 1'($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom),
            lv, mk, 1'($urandom), 1'($urandom), "random");
      if ($urandom_range(0, 7) == 0) idle_check("random gap");
    end

    // R9: reset mid-run clears counters
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_bytes = '0;
    exp_pkts = '0;
    check("R9 byte_count after reset", 64'(byte_count), 64'd0);
    check("R9 pkt_count after reset", 64'(pkt_count), 64'd0);
    frame(16'd42, 1'b1, 1'b0, 1'b0, 8'd2, 8'd8, 1'b1, 1'b0, "post reset R1 R6");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule